// File: doc/BRIEF.md
# On-Chip Stimulus Replay and Capture Controller

This block lets a host test a streaming datapath in silicon without a processor. Through one memory-mapped slave port the host loads input words into a stimulus memory and the expected outputs into a reference memory. It then sets a run length and issues a start command. The controller plays the stimulus into the datapath one word per cycle. Each output word that the datapath marks valid is written into a capture memory and compared bit for bit with the reference word of the same output index.

The write and compare pointers move only on the datapath's output-valid strobe, so they stay aligned with the datapath whatever its latency. A sticky mismatch flag records any difference, and a register holds the index of the first one. A timeout flag is set when the outputs stop arriving. When the run ends a done flag rises, which the host can poll and a logic analyser can use as a trigger. The datapath inside is a stand-in: it multiplies each input by a constant and delays it by a set number of register stages.

Top module: `stim_capture_ctrl`

## Requirements
- R1: After reset the status register reads 0 (bit0 busy, bit1 done, bit2 mismatch, bit3 timeout), `run_done_o` and `run_pass_o` are low, and no run starts until the host writes a start command.
- R2: The host address selects a region by its top two bits: 0 is stimulus, 1 is reference, 2 is capture (read-only) and 3 is registers, with the word index in the low AW bits. A host read returns its data on `hst_rdata` in the cycle after `hst_rd` is sampled.
- R3: Register offset 1 holds the run length N. A written value above 2^AW is stored as 2^AW. A start command (offset 0, bit0) while N is 0 is ignored and leaves the status at 0.
- R4: During a run the controller feeds stimulus words 0..N-1 in order into the datapath, whose output is (input × SCALE) mod 2^DW. Only the first N valid outputs are written, to capture words 0..N-1, and capture words at or above N keep their old contents.
- R5: Busy is set from the start edge. Busy and done are never high together. With a gap-free datapath, done rises exactly N+LAT+2 clock edges after the edge that accepts the start.
- R6: The mismatch flag is set if any captured word differs from its reference word. `run_pass_o` is high only when done is set and neither mismatch nor timeout is set.
- R7: Register offset 3 reads the output index of the first mismatch of the run.
- R8: Mismatch, timeout and first-index stay set until a control write with bit1 set while idle. That write returns all of them, and done, to 0. A new start clears only done.
- R9: While busy, host writes to the memories, the length register and the control register are ignored, and host reads of any memory return 0.
- R10: If N valid outputs have not all been compared after N+LAT_BUDGET cycles of busy, the run stops with the timeout flag and done both set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| hst_wr | input | 1 | Host write strobe |
| hst_rd | input | 1 | Host read strobe |
| hst_addr | input | AW+2 | Host word address: region in top two bits |
| hst_wdata | input | DW | Host write data |
| hst_rdata | output | DW | Host read data, valid one cycle after the read strobe |
| run_done_o | output | 1 | Run finished; trigger indicator |
| run_pass_o | output | 1 | Run finished with no mismatch and no timeout |

## Verification
Host reads are checked at the falling edge one cycle after the strobe, because the data passes through one register. Run completion is checked by counting rising edges from the edge that accepts the start: a read cycle, LAT datapath stages and one compare stage give N+LAT+2 edges. The bench requires that exact count, for N=16 and N=4. Captured words, flags and the first-mismatch index are read only after done. A second instance with a latency budget of 1 runs next to the first and shows the timeout path.

// File: rtl/scc_pkg.sv
package scc_pkg;
  typedef enum logic [1:0] {
    RG_STIM = 2'd0,
    RG_REF  = 2'd1,
    RG_CAP  = 2'd2,
    RG_REG  = 2'd3
  } region_e;

  localparam logic [1:0] OFF_CTRL = 2'd0;
  localparam logic [1:0] OFF_LEN  = 2'd1;
  localparam logic [1:0] OFF_STAT = 2'd2;
  localparam logic [1:0] OFF_BAD  = 2'd3;
endpackage

// File: rtl/scc_ram.sv
module scc_ram #(
  parameter int DW = 8,
  parameter int AW = 4
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic          re,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];
  logic [DW-1:0] rdata_q;

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    if (re) rdata_q <= mem[raddr];
  end

  assign rdata = rdata_q;
endmodule

// File: rtl/scc_datapath.sv
module scc_datapath #(
  parameter int DW    = 8,
  parameter int LAT   = 3,
  parameter int SCALE = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_v,
  input  logic [DW-1:0] in_d,
  output logic          out_v,
  output logic [DW-1:0] out_d
);
  localparam int PW = 2 * DW;

  logic [PW-1:0] prod;
  logic          v_q [LAT];
  logic [DW-1:0] d_q [LAT];

  assign prod = PW'(in_d) * PW'(SCALE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      v_q[0] <= 1'b0;
      d_q[0] <= '0;
    end else begin
      v_q[0] <= in_v;
      if (in_v) d_q[0] <= prod[DW-1:0];
    end
  end

  for (genvar g = 1; g < LAT; g++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        v_q[g] <= 1'b0;
        d_q[g] <= '0;
      end else begin
        v_q[g] <= v_q[g-1];
        if (v_q[g-1]) d_q[g] <= d_q[g-1];
      end
    end
  end

  assign out_v = v_q[LAT-1];
  assign out_d = d_q[LAT-1];
endmodule

// File: rtl/scc_seq.sv
module scc_seq #(
  parameter int DW         = 8,
  parameter int AW         = 4,
  parameter int LW         = 5,
  parameter int TW         = 6,
  parameter int LAT_BUDGET = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_req,
  input  logic          clr_req,
  input  logic [LW-1:0] len,
  input  logic          out_v,
  input  logic [DW-1:0] out_d,
  input  logic [DW-1:0] ref_q,
  output logic          busy,
  output logic          done,
  output logic          fail,
  output logic          tmo,
  output logic [AW-1:0] bad_idx,
  output logic [LW-1:0] out_cnt,
  output logic          stim_re,
  output logic [AW-1:0] stim_raddr,
  output logic          feed_v,
  output logic          cap_we,
  output logic [AW-1:0] cap_waddr,
  output logic [DW-1:0] cap_wdata,
  output logic          ref_re,
  output logic [AW-1:0] ref_raddr
);
  logic          busy_q, busy_d, done_q, done_d, fail_q, fail_d, tmo_q, tmo_d;
  logic [AW-1:0] bad_q, bad_d;
  logic [LW-1:0] issue_q, issue_d, out_q, out_d_cnt;
  logic [TW-1:0] timer_q, timer_d;
  logic          feed_q, s1_v_q, s1_v_d;
  logic [DW-1:0] s1_d_q, s1_d_d;
  logic [AW-1:0] s1_i_q, s1_i_d;
  logic          rd_go, take, mis, last, expire, go, wipe;

  always_comb begin
    rd_go  = busy_q && (issue_q < len);
    take   = busy_q && out_v && (out_q < len);
    mis    = s1_v_q && (s1_d_q != ref_q);
    last   = busy_q && s1_v_q && (LW'(s1_i_q) == (len - LW'(1)));
    expire = busy_q && !last && (timer_q == (TW'(len) + TW'(LAT_BUDGET)));
    go     = !busy_q && start_req && (len != '0);
    wipe   = !busy_q && clr_req;

    busy_d = busy_q;
    if (go) busy_d = 1'b1;
    if (last || expire) busy_d = 1'b0;

    done_d = done_q;
    if (wipe || go) done_d = 1'b0;
    if (last || expire) done_d = 1'b1;

    fail_d = fail_q;
    bad_d  = bad_q;
    tmo_d  = tmo_q;
    if (wipe) begin
      fail_d = 1'b0;
      bad_d  = '0;
      tmo_d  = 1'b0;
    end
    if (mis) begin
      fail_d = 1'b1;
      if (!fail_q) bad_d = s1_i_q;
    end
    if (expire) tmo_d = 1'b1;

    issue_d = issue_q;
    if (wipe || go) issue_d = '0;
    else if (rd_go) issue_d = issue_q + LW'(1);

    out_d_cnt = out_q;
    if (wipe || go) out_d_cnt = '0;
    else if (take) out_d_cnt = out_q + LW'(1);

    timer_d = timer_q;
    if (go) timer_d = '0;
    else if (busy_q) timer_d = timer_q + TW'(1);

    s1_v_d = take;
    s1_d_d = take ? out_d : s1_d_q;
    s1_i_d = take ? out_q[AW-1:0] : s1_i_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q  <= 1'b0;
      done_q  <= 1'b0;
      fail_q  <= 1'b0;
      tmo_q   <= 1'b0;
      bad_q   <= '0;
      issue_q <= '0;
      out_q   <= '0;
      timer_q <= '0;
      feed_q  <= 1'b0;
      s1_v_q  <= 1'b0;
      s1_d_q  <= '0;
      s1_i_q  <= '0;
    end else begin
      busy_q  <= busy_d;
      done_q  <= done_d;
      fail_q  <= fail_d;
      tmo_q   <= tmo_d;
      bad_q   <= bad_d;
      issue_q <= issue_d;
      out_q   <= out_d_cnt;
      timer_q <= timer_d;
      feed_q  <= rd_go;
      s1_v_q  <= s1_v_d;
      s1_d_q  <= s1_d_d;
      s1_i_q  <= s1_i_d;
    end
  end

  assign busy       = busy_q;
  assign done       = done_q;
  assign fail       = fail_q;
  assign tmo        = tmo_q;
  assign bad_idx    = bad_q;
  assign out_cnt    = out_q;
  assign stim_re    = rd_go;
  assign stim_raddr = issue_q[AW-1:0];
  assign feed_v     = feed_q;
  assign cap_we     = take;
  assign cap_waddr  = out_q[AW-1:0];
  assign cap_wdata  = out_d;
  assign ref_re     = take;
  assign ref_raddr  = out_q[AW-1:0];
endmodule

// File: rtl/stim_capture_ctrl.sv
module stim_capture_ctrl
  import scc_pkg::*;
#(
  parameter int DW         = 8,
  parameter int AW         = 4,
  parameter int LAT        = 3,
  parameter int SCALE      = 3,
  parameter int LAT_BUDGET = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            hst_wr,
  input  logic            hst_rd,
  input  logic [AW+1:0]   hst_addr,
  input  logic [DW-1:0]   hst_wdata,
  output logic [DW-1:0]   hst_rdata,
  output logic            run_done_o,
  output logic            run_pass_o
);
  localparam int DEPTH = 1 << AW;
  localparam int LW    = AW + 1;
  localparam int TW    = $clog2(DEPTH + LAT_BUDGET + 1) + 1;

  logic [1:0]    rst_sync_q;
  logic          rst_sn;
  region_e       hreg;
  logic [1:0]    hoff;
  logic [AW-1:0] hidx;

  logic          busy, done, fail, tmo;
  logic [AW-1:0] bad_idx;
  logic [LW-1:0] out_cnt, len_q, len_d;
  logic          start_req, clr_req, len_we;

  logic          seq_stim_re, seq_ref_re, feed_v, cap_we;
  logic [AW-1:0] seq_stim_addr, seq_ref_addr, cap_waddr;
  logic [DW-1:0] cap_wdata;
  logic [DW-1:0] stim_q, ref_q, cap_q;
  logic          dp_v;
  logic [DW-1:0] dp_d;

  logic          stim_we, stim_re, ref_we, ref_re, cap_re;
  logic [AW-1:0] stim_raddr, ref_raddr;

  region_e       rsel_q, rsel_d;
  logic          blank_q, blank_d;
  logic [DW-1:0] rreg_q, rreg_d, reg_val;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_sn = rst_sync_q[1];

  assign hreg = region_e'(hst_addr[AW+1:AW]);
  assign hoff = hst_addr[1:0];
  assign hidx = hst_addr[AW-1:0];

  always_comb begin
    start_req = hst_wr && (hreg == RG_REG) && (hoff == OFF_CTRL) && hst_wdata[0];
    clr_req   = hst_wr && (hreg == RG_REG) && (hoff == OFF_CTRL) && hst_wdata[1];
    len_we    = hst_wr && (hreg == RG_REG) && (hoff == OFF_LEN) && !busy;
    len_d     = len_q;
    if (len_we) len_d = (hst_wdata > DW'(DEPTH)) ? LW'(DEPTH) : hst_wdata[LW-1:0];
  end

  always_comb begin
    stim_we    = hst_wr && (hreg == RG_STIM) && !busy;
    ref_we     = hst_wr && (hreg == RG_REF) && !busy;
    stim_re    = busy ? seq_stim_re : (hst_rd && (hreg == RG_STIM));
    stim_raddr = busy ? seq_stim_addr : hidx;
    ref_re     = busy ? seq_ref_re : (hst_rd && (hreg == RG_REF));
    ref_raddr  = busy ? seq_ref_addr : hidx;
    cap_re     = !busy && hst_rd && (hreg == RG_CAP);
  end

  always_comb begin
    case (hoff)
      OFF_LEN:  reg_val = DW'(len_q);
      OFF_STAT: reg_val = DW'({tmo, fail, done, busy});
      OFF_BAD:  reg_val = DW'(bad_idx);
      default:  reg_val = '0;
    endcase
    rsel_d  = hst_rd ? hreg : rsel_q;
    blank_d = hst_rd ? busy : blank_q;
    rreg_d  = (hst_rd && (hreg == RG_REG)) ? reg_val : rreg_q;
  end

  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) begin
      len_q   <= '0;
      rsel_q  <= RG_REG;
      blank_q <= 1'b0;
      rreg_q  <= '0;
    end else begin
      len_q   <= len_d;
      rsel_q  <= rsel_d;
      blank_q <= blank_d;
      rreg_q  <= rreg_d;
    end
  end

  always_comb begin
    case (rsel_q)
      RG_STIM: hst_rdata = blank_q ? '0 : stim_q;
      RG_REF:  hst_rdata = blank_q ? '0 : ref_q;
      RG_CAP:  hst_rdata = blank_q ? '0 : cap_q;
      default: hst_rdata = rreg_q;
    endcase
  end

  scc_ram #(.DW(DW), .AW(AW)) u_stim (
    .clk(clk), .we(stim_we), .waddr(hidx), .wdata(hst_wdata),
    .re(stim_re), .raddr(stim_raddr), .rdata(stim_q)
  );

  scc_ram #(.DW(DW), .AW(AW)) u_ref (
    .clk(clk), .we(ref_we), .waddr(hidx), .wdata(hst_wdata),
    .re(ref_re), .raddr(ref_raddr), .rdata(ref_q)
  );

  scc_ram #(.DW(DW), .AW(AW)) u_cap (
    .clk(clk), .we(cap_we), .waddr(cap_waddr), .wdata(cap_wdata),
    .re(cap_re), .raddr(hidx), .rdata(cap_q)
  );

  scc_datapath #(.DW(DW), .LAT(LAT), .SCALE(SCALE)) u_dp (
    .clk(clk), .rst_n(rst_sn), .in_v(feed_v), .in_d(stim_q),
    .out_v(dp_v), .out_d(dp_d)
  );

  scc_seq #(.DW(DW), .AW(AW), .LW(LW), .TW(TW), .LAT_BUDGET(LAT_BUDGET)) u_seq (
    .clk(clk), .rst_n(rst_sn), .start_req(start_req), .clr_req(clr_req), .len(len_q),
    .out_v(dp_v), .out_d(dp_d), .ref_q(ref_q),
    .busy(busy), .done(done), .fail(fail), .tmo(tmo), .bad_idx(bad_idx), .out_cnt(out_cnt),
    .stim_re(seq_stim_re), .stim_raddr(seq_stim_addr), .feed_v(feed_v),
    .cap_we(cap_we), .cap_waddr(cap_waddr), .cap_wdata(cap_wdata),
    .ref_re(seq_ref_re), .ref_raddr(seq_ref_addr)
  );

  assign run_done_o = done;
  assign run_pass_o = done && !fail && !tmo;
endmodule

// File: rtl/scc_chk.sv
module scc_chk #(
  parameter int AW = 4,
  parameter int LW = 5
) (
  input logic          clk,
  input logic          rst_n,
  input logic          busy,
  input logic          done,
  input logic          fail,
  input logic          tmo,
  input logic          clr,
  input logic          hst_wr,
  input logic [LW-1:0] len,
  input logic [LW-1:0] out_cnt,
  input logic [AW-1:0] bad_idx
);
  assert_busy_done_excl_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !(busy && done));

  assert_start_needs_len_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> ($past(len) != '0));

  assert_capture_bounded_R4: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (out_cnt <= len));

  assert_fail_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (fail && !clr) |=> fail);

  assert_first_idx_range_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fail) |-> (LW'(bad_idx) < len));

  assert_len_frozen_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && hst_wr) |=> $stable(len));

  assert_timeout_ends_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tmo) |-> (done && !busy));
endmodule

bind stim_capture_ctrl scc_chk #(.AW(AW), .LW(AW + 1)) u_chk (
  .clk(clk), .rst_n(rst_sn), .busy(busy), .done(done), .fail(fail), .tmo(tmo),
  .clr(clr_req), .hst_wr(hst_wr), .len(len_q), .out_cnt(out_cnt), .bad_idx(bad_idx)
);

// File: tb/sim_stim_capture_ctrl.sv
module sim_stim_capture_ctrl;
  localparam int DW = 8;
  localparam int AW = 4;
  localparam int LAT = 3;
  localparam int SCALE = 3;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          hst_wr = 1'b0;
  logic          hst_rd = 1'b0;
  logic [AW+1:0] hst_addr = '0;
  logic [DW-1:0] hst_wdata = '0;
  logic [DW-1:0] rd0, rd1;
  logic          done0, pass0, done1, pass1;
  int total = 0;
  int bad = 0;

  always #4 clk = ~clk;

  stim_capture_ctrl #(.DW(DW), .AW(AW), .LAT(LAT), .SCALE(SCALE), .LAT_BUDGET(8)) u0 (
    .clk(clk), .rst_n(rst_n), .hst_wr(hst_wr), .hst_rd(hst_rd), .hst_addr(hst_addr),
    .hst_wdata(hst_wdata), .hst_rdata(rd0), .run_done_o(done0), .run_pass_o(pass0)
  );

  stim_capture_ctrl #(.DW(DW), .AW(AW), .LAT(LAT), .SCALE(SCALE), .LAT_BUDGET(1)) u1 (
    .clk(clk), .rst_n(rst_n), .hst_wr(hst_wr), .hst_rd(hst_rd), .hst_addr(hst_addr),
    .hst_wdata(hst_wdata), .hst_rdata(rd1), .run_done_o(done1), .run_pass_o(pass1)
  );

  function automatic int stimv(int k);
    return (k * 7 + 1) & 255;
  endfunction

  function automatic int expv(int k);
    return (stimv(k) * SCALE) & 255;
  endfunction

  function automatic logic [AW+1:0] ad(int reg_sel, int idx);
    return {2'(reg_sel), 4'(idx)};
  endfunction

  task automatic chk(string req, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic hw(logic [AW+1:0] a, int d);
    @(negedge clk);
    hst_wr = 1'b1; hst_addr = a; hst_wdata = 8'(d);
    @(posedge clk);
    @(negedge clk);
    hst_wr = 1'b0;
  endtask

  task automatic hr(logic [AW+1:0] a, output int v0, output int v1);
    @(negedge clk);
    hst_rd = 1'b1; hst_addr = a;
    @(posedge clk);
    @(negedge clk);
    hst_rd = 1'b0;
    v0 = int'(rd0); v1 = int'(rd1);
  endtask

  task automatic wait_done(output int c);
    c = 0;
    while (!done0 && c < 200) begin
      @(posedge clk);
      c++;
      @(negedge clk);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int v0, v1, c;
    repeat (4) @(posedge clk);
    rst_n = 1'b1;
    repeat (4) @(posedge clk);

    // R1: reset state
    hr(ad(3, 2), v0, v1);
    chk("R1 status", v0, 0);
    chk("R1 done", int'(done0), 0);
    chk("R1 pass", int'(pass0), 0);

    // R2: memory load and readback
    for (int k = 0; k < 16; k++) begin
      hw(ad(0, k), stimv(k));
      hw(ad(1, k), expv(k));
    end
    for (int k = 0; k < 16; k++) begin
      hr(ad(0, k), v0, v1);
      chk("R2 stim readback", v0, stimv(k));
      hr(ad(1, k), v0, v1);
      chk("R2 ref readback", v0, expv(k));
    end

    // R3: length saturation and zero-length start
    hw(ad(3, 1), 31);
    hr(ad(3, 1), v0, v1);
    chk("R3 len saturate", v0, 16);
    hw(ad(3, 1), 0);
    hw(ad(3, 0), 1);
    repeat (30) @(posedge clk);
    @(negedge clk);
    hr(ad(3, 2), v0, v1);
    chk("R3 zero-length start ignored", v0, 0);

    // Run 1: full length, all references correct
    hw(ad(3, 1), 16);
    hw(ad(3, 0), 1);
    wait_done(c);
    chk("R5 done latency N=16", c, 16 + LAT + 2);
    chk("R6 pass", int'(pass0), 1);
    hr(ad(3, 2), v0, v1);
    chk("R6 status done only", v0, 2);
    chk("R10 timeout status", v1, 10);
    chk("R10 timeout pass low", int'(pass1), 0);
    for (int k = 0; k < 16; k++) begin
      hr(ad(2, k), v0, v1);
      chk("R4 capture word", v0, expv(k));
    end

    // R8: clear
    hw(ad(3, 0), 2);
    hr(ad(3, 2), v0, v1);
    chk("R8 clear status", v0, 0);
    chk("R8 clear timeout", v1, 0);

    // Run 2: corrupted references at 5 and 11
    hw(ad(1, 5), expv(5) ^ 1);
    hw(ad(1, 11), expv(11) ^ 1);
    hw(ad(3, 0), 1);
    wait_done(c);
    chk("R5 done latency rerun", c, 16 + LAT + 2);
    chk("R6 pass low on mismatch", int'(pass0), 0);
    hr(ad(3, 2), v0, v1);
    chk("R6 status mismatch", v0, 6);
    hr(ad(3, 3), v0, v1);
    chk("R7 first mismatch index", v0, 5);
    hw(ad(3, 0), 1);
    wait_done(c);
    hr(ad(3, 2), v0, v1);
    chk("R8 mismatch sticky over start", v0, 6);
    hw(ad(3, 0), 2);
    hr(ad(3, 3), v0, v1);
    chk("R8 clear first index", v0, 0);
    hr(ad(3, 2), v0, v1);
    chk("R8 clear mismatch", v0, 0);

    // Run 3: N=4 with host traffic while busy
    hw(ad(3, 1), 4);
    hw(ad(3, 0), 1);
    hw(ad(0, 1), 85);
    hr(ad(0, 1), v0, v1);
    chk("R9 memory read while busy", v0, 0);
    hw(ad(3, 1), 9);
    hr(ad(3, 2), v0, v1);
    chk("R5 busy during run", v0, 1);
    wait_done(c);
    chk("R6 pass short run", int'(pass0), 1);
    hr(ad(0, 1), v0, v1);
    chk("R9 stim write ignored", v0, stimv(1));
    hr(ad(3, 1), v0, v1);
    chk("R9 len write ignored", v0, 4);
    for (int k = 0; k < 6; k++) begin
      hr(ad(2, k), v0, v1);
      chk("R4 capture short run", v0, expv(k));
    end
    hw(ad(3, 0), 2);
    hw(ad(3, 0), 1);
    wait_done(c);
    chk("R5 done latency N=4", c, 4 + LAT + 2);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule